// File: doc/BRIEF.md
# Nibble Shift, Rotate and Mirror Unit

This unit carries out the single-operand bit operations of a small 4-bit controller core. Each cycle it may accept one decoded operation: the 6-bit opcode prefix, the 4-bit function code, the row and column address of the memory operand, the nibble already read from that address, and the current carry flag. One cycle later it returns the result nibble. The result goes to the same row and column, under a single write strobe, and the updated carry flag comes out on its own port.

Three operations change memory. The first is a logical right shift through carry. The second is a right rotate through carry. The third is a mirror that swaps the outer pair and the inner pair of bits. A no-operation code, any function code the unit does not know, a prefix that is not all ones, or an idle cycle all produce no write, and the carry passes through unchanged. The data memory and the wider instruction decoder sit outside the unit.

Top module: `nib_bitop_unit`

## Requirements
- R1: With valid_i high, prefix_i = 111111 and func_i = 0000 (shift), wr_data_o takes the input nibble shifted one place toward bit 0 with 0 entering bit 3, and carry_o takes the old bit 0.
- R2: With valid_i high, prefix_i = 111111 and func_i = 0001 (rotate), wr_data_o takes the input nibble shifted one place toward bit 0 with carry_i entering bit 3, and carry_o takes the old bit 0.
- R3: With valid_i high, prefix_i = 111111 and func_i = 0110 (mirror), wr_data_o holds bit 3 swapped with bit 0 and bit 2 swapped with bit 1, and carry_o equals carry_i.
- R4: With valid_i high, prefix_i = 111111 and func_i = 1111 (no-operation), wr_en_o stays low and carry_o equals carry_i.
- R5: Any other function code, a prefix that is not 111111, or valid_i low gives wr_en_o low, and carry_o equals carry_i.
- R6: wr_en_o, wr_data_o, wr_row_o, wr_col_o and carry_o are registered and follow the accepted inputs one clock later. wr_row_o and wr_col_o equal row_i and col_i, and wr_en_o is high only for the shift, rotate and mirror codes.
- R7: While rst_ni is low, wr_en_o, wr_data_o, wr_row_o, wr_col_o and carry_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation present this cycle |
| prefix_i | input | 6 | Opcode prefix, must be 111111 |
| func_i | input | 4 | Function code |
| row_i | input | 4 | Operand row address |
| col_i | input | 4 | Operand column address |
| rd_data_i | input | 4 | Nibble read from the operand address |
| carry_i | input | 1 | Current carry flag |
| wr_en_o | output | 1 | Write-back strobe |
| wr_row_o | output | 4 | Write-back row address |
| wr_col_o | output | 4 | Write-back column address |
| wr_data_o | output | 4 | Result nibble |
| carry_o | output | 1 | Updated carry flag |

## Verification
On every cycle the assertions check four things. A strobe appears only after a valid all-ones-prefix operation. The address is echoed. The shift fills bit 3 with 0, and the rotate fills it with the old carry. The carry is held across mirror, no-operation and rejected cycles. The bench's sweeps cover the full result values of every function code over every nibble and both carry values, the rejection of wrong prefixes and idle cycles, and the reset values.

// File: rtl/nib_bitop_pkg.sv
package nib_bitop_pkg;
  localparam int unsigned PFX_W = 6;
  localparam int unsigned FN_W  = 4;

  localparam logic [PFX_W-1:0] PFX_BITOP = '1;
  localparam logic [FN_W-1:0]  FN_SHR    = 4'b0000;
  localparam logic [FN_W-1:0]  FN_ROR    = 4'b0001;
  localparam logic [FN_W-1:0]  FN_MIR    = 4'b0110;
  localparam logic [FN_W-1:0]  FN_NOP    = 4'b1111;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_SHR  = 2'd1,
    K_ROR  = 2'd2,
    K_MIR  = 2'd3
  } op_kind_e;
endpackage

// File: rtl/nib_bitop_dec.sv
module nib_bitop_dec
  import nib_bitop_pkg::*;
(
  input  logic             valid_i,
  input  logic [PFX_W-1:0] prefix_i,
  input  logic [FN_W-1:0]  func_i,
  output op_kind_e         kind_o
);
  always_comb begin
    kind_o = K_NONE;
    if (valid_i && prefix_i == PFX_BITOP) begin
      unique case (func_i)
        FN_SHR:  kind_o = K_SHR;
        FN_ROR:  kind_o = K_ROR;
        FN_MIR:  kind_o = K_MIR;
        default: kind_o = K_NONE; // no-op and unknown codes
      endcase
    end
  end
endmodule

// File: rtl/nib_bitop_alu.sv
module nib_bitop_alu
  import nib_bitop_pkg::*;
#(
  parameter int unsigned NIB_W = 4
) (
  input  op_kind_e         kind_i,
  input  logic [NIB_W-1:0] data_i,
  input  logic             carry_i,
  output logic [NIB_W-1:0] data_o,
  output logic             carry_o,
  output logic             wr_o
);
  localparam int unsigned MSB = NIB_W - 1;

  logic [NIB_W-1:0] mirror;

  for (genvar g = 0; g < NIB_W; g++) begin : g_mir
    assign mirror[g] = data_i[MSB-g];
  end

  always_comb begin
    data_o  = data_i;
    carry_o = carry_i;
    wr_o    = 1'b0;
    unique case (kind_i)
      K_SHR: begin
        data_o  = {1'b0, data_i[MSB:1]};
        carry_o = data_i[0];
        wr_o    = 1'b1;
      end
      K_ROR: begin
        data_o  = {carry_i, data_i[MSB:1]};
        carry_o = data_i[0];
        wr_o    = 1'b1;
      end
      K_MIR: begin
        data_o  = mirror;
        wr_o    = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/nib_bitop_unit.sv
module nib_bitop_unit
  import nib_bitop_pkg::*;
#(
  parameter int unsigned NIB_W  = 4,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [PFX_W-1:0]  prefix_i,
  input  logic [FN_W-1:0]   func_i,
  input  logic [ADDR_W-1:0] row_i,
  input  logic [ADDR_W-1:0] col_i,
  input  logic [NIB_W-1:0]  rd_data_i,
  input  logic              carry_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_row_o,
  output logic [ADDR_W-1:0] wr_col_o,
  output logic [NIB_W-1:0]  wr_data_o,
  output logic              carry_o
);
  localparam int unsigned MSB = NIB_W - 1;

  op_kind_e         kind;
  logic [NIB_W-1:0] res_d;
  logic             cy_d;
  logic             wr_d;

  nib_bitop_dec u_dec (
    .valid_i  (valid_i),
    .prefix_i (prefix_i),
    .func_i   (func_i),
    .kind_o   (kind)
  );

  nib_bitop_alu #(.NIB_W(NIB_W)) u_alu (
    .kind_i  (kind),
    .data_i  (rd_data_i),
    .carry_i (carry_i),
    .data_o  (res_d),
    .carry_o (cy_d),
    .wr_o    (wr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_o   <= 1'b0;
      wr_row_o  <= '0;
      wr_col_o  <= '0;
      wr_data_o <= '0;
      carry_o   <= 1'b0;
    end else begin
      wr_en_o   <= wr_d;
      wr_row_o  <= row_i;
      wr_col_o  <= col_i;
      wr_data_o <= res_d;
      carry_o   <= cy_d;
    end
  end

  AST_WR_NEEDS_PFX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(valid_i && prefix_i == PFX_BITOP)); // R5
  AST_NOP_NO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && func_i == FN_NOP) |=> !wr_en_o); // R4
  AST_ADDR_ECHO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_row_o == $past(row_i) && wr_col_o == $past(col_i))); // R6
  AST_SHR_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && prefix_i == PFX_BITOP && func_i == FN_SHR)
      |=> (wr_data_o[MSB] == 1'b0 && carry_o == $past(rd_data_i[0]))); // R1
  AST_ROR_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && prefix_i == PFX_BITOP && func_i == FN_ROR)
      |=> (wr_data_o[MSB] == $past(carry_i) && carry_o == $past(rd_data_i[0]))); // R2
  AST_MIR_CY_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && prefix_i == PFX_BITOP && func_i == FN_MIR) |=> carry_o == $past(carry_i)); // R3
  AST_IDLE_CY_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (carry_o == $past(carry_i) && !wr_en_o)); // R5
endmodule

// File: tb/sim_nib_bitop_unit.sv
module sim_nib_bitop_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [5:0] prefix_i = '0;
  logic [3:0] func_i = '0;
  logic [3:0] row_i = '0;
  logic [3:0] col_i = '0;
  logic [3:0] rd_data_i = '0;
  logic       carry_i = 1'b0;
  logic       wr_en_o;
  logic [3:0] wr_row_o, wr_col_o, wr_data_o;
  logic       carry_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk_i = ~clk_i;

  nib_bitop_unit u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .prefix_i(prefix_i),
    .func_i(func_i), .row_i(row_i), .col_i(col_i), .rd_data_i(rd_data_i),
    .carry_i(carry_i), .wr_en_o(wr_en_o), .wr_row_o(wr_row_o),
    .wr_col_o(wr_col_o), .wr_data_o(wr_data_o), .carry_o(carry_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, sample at the following negedge (one register stage)
  task automatic step(input bit v, input logic [5:0] p, input logic [3:0] f,
                      input logic [3:0] d, input bit c, input logic [3:0] r,
                      input logic [3:0] k);
    valid_i = v; prefix_i = p; func_i = f; rd_data_i = d; carry_i = c;
    row_i = r; col_i = k;
    @(negedge clk_i);
  endtask

  function automatic int mir(input int d);
    return ((d & 1) << 3) | ((d & 2) << 1) | ((d & 4) >> 1) | ((d & 8) >> 3);
  endfunction

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R7 wr_en", wr_en_o, 0);
    chk("R7 data", wr_data_o, 0);
    chk("R7 addr", {wr_row_o, wr_col_o}, 0);
    chk("R7 carry", carry_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int f = 0; f < 16; f++) begin
      for (int d = 0; d < 16; d++) begin
        for (int c = 0; c < 2; c++) begin
          int r = (d + f) & 15;
          int k = (d ^ (f << 1)) & 15;
          step(1'b1, 6'h3F, f[3:0], d[3:0], c[0], r[3:0], k[3:0]);
          case (f)
            0: begin // R1
              chk("R1 wr", wr_en_o, 1);
              chk("R1 data", wr_data_o, d >> 1);
              chk("R1 carry", carry_o, d & 1);
            end
            1: begin // R2
              chk("R2 wr", wr_en_o, 1);
              chk("R2 data", wr_data_o, (c << 3) | (d >> 1));
              chk("R2 carry", carry_o, d & 1);
            end
            6: begin // R3
              chk("R3 wr", wr_en_o, 1);
              chk("R3 data", wr_data_o, mir(d));
              chk("R3 carry", carry_o, c);
            end
            15: begin // R4
              chk("R4 wr", wr_en_o, 0);
              chk("R4 carry", carry_o, c);
            end
            default: begin // R5
              chk("R5 wr", wr_en_o, 0);
              chk("R5 carry", carry_o, c);
            end
          endcase
          if (f == 0 || f == 1 || f == 6)
            chk("R6 addr", {wr_row_o, wr_col_o}, (r << 4) | k);
        end
      end
    end

    // wrong prefix and idle cycles: R5
    for (int p = 0; p < 63; p++) begin
      for (int c = 0; c < 2; c++) begin
        step(1'b1, p[5:0], 4'b0000, 4'b1011, c[0], 4'h3, 4'h5);
        chk("R5 pfx wr", wr_en_o, 0);
        chk("R5 pfx carry", carry_o, c);
      end
    end
    for (int c = 0; c < 2; c++) begin
      step(1'b0, 6'h3F, 4'b0001, 4'b0111, c[0], 4'h1, 4'h2);
      chk("R5 idle wr", wr_en_o, 0);
      chk("R5 idle carry", carry_o, c);
    end

    // back-to-back latency: R6
    valid_i = 1'b1; prefix_i = 6'h3F; func_i = 4'b0000; rd_data_i = 4'b1001;
    carry_i = 1'b0; row_i = 4'hA; col_i = 4'hC;
    @(posedge clk_i); #1;
    func_i = 4'b1111;
    chk("R6 one-cycle wr", wr_en_o, 1);
    chk("R6 one-cycle data", wr_data_o, 4'b0100);
    @(posedge clk_i); #1;
    chk("R6 next wr low", wr_en_o, 0);

    // reset again mid-run: R7
    rst_ni = 1'b0; #1;
    chk("R7 async carry", carry_o, 0);
    chk("R7 async wr", wr_en_o, 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        fails++;
        checks++;
        $display("FAIL watchdog act=running exp=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule